// File: doc/BRIEF.md
# Double-Buffered Asynchronous Serial Receiver

This block takes asynchronous serial frames from one input line and hands each received character to a controller over a parallel port. A baud generator outside the block supplies a one-clock enable that pulses sixteen times per bit period. The receiver passes the line through a synchronizer. It then waits for a falling edge and checks at mid-cell that the start bit is real. After that it samples each data bit once per bit period, at the centre of the cell. The data bits enter a shift register, least significant bit first.

When the stop cell has been sampled, the byte is copied into a separate holding register, and a ready flag tells the controller that a byte is waiting. The controller takes the byte by pulling an active-low read strobe. Because there are two registers, the next frame can shift in while the previous byte is still unread. If a new byte arrives before the old one has been read, an overrun flag is raised. If the stop sample is low, a framing-error flag is raised. Start and stop bits never reach the holding register.

Top module: `serial_rx_dbuf`

## Requirements
- R1: A synchronous active-high reset clears `data_ready`, `overrun` and `frame_err` and returns the receiver to idle.
- R2: A falling edge on `rxd_in` that is seen on a `tick` starts a 4-bit divide counter. If the line is high again at the eighth tick (count 7, mid-cell), the event is treated as a glitch, no byte is produced and the receiver returns to idle.
- R3: Data bits are sent least significant bit first. Each one is sampled 16 ticks after the previous sample point, starting from the confirmed start-bit centre. `rx_data[0]` holds the first data bit received.
- R4: Start and stop bits are stripped. `rx_data` changes only when a completed byte is loaded into the holding register, and it holds its value otherwise.
- R5: Each completed frame produces exactly one single-cycle internal load, and `data_ready` is high in the cycle after that load.
- R6: At the first clock edge where `rd_n` is low and no load occurs, `data_ready` and `overrun` are both cleared.
- R7: Reception is double buffered: a following frame is received correctly while the previous byte is still unread, including frames sent back to back with a single stop bit.
- R8: If a byte is loaded while `data_ready` is high and `rd_n` is high, `overrun` is set. The new byte overwrites `rx_data`, and `overrun` stays set until a read or a reset.
- R9: A low stop-bit sample sets `frame_err` for that byte, and the byte is still loaded. A correct stop bit clears `frame_err` at the next load. After a framing error, a new start bit is accepted only once the line has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Enable pulse at 16 times the baud rate |
| rxd_in | input | 1 | Asynchronous serial input, idle high |
| rd_n | input | 1 | Active-low read strobe from the controller |
| rx_data | output | DATA_BITS | Holding register contents |
| data_ready | output | 1 | A byte is waiting in the holding register |
| overrun | output | 1 | An unread byte was overwritten |
| frame_err | output | 1 | The last loaded byte had a low stop sample |

## Verification
On every cycle, the assertions check the handover between the frame engine and the holding register: a load is a single pulse, the ready flag follows a load, a read clears the ready and overrun flags, overrun is set on an unread load and then stays set, `frame_err` matches the stop sample, and `rx_data` is stable between loads. Bit timing, least-significant-bit-first assembly, glitch rejection and reception of back-to-back frames depend on the serial waveform, so only the bench's scenarios can show them. The bench does this by comparing received bytes against what it sent.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_t;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  // Reset to the idle (high) level so no false start is seen after reset
  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/rx_frame_engine.sv
module rx_frame_engine
  import serial_rx_pkg::*;
#(
  parameter int DATA_BITS  = 8,
  parameter int OVERSAMPLE = 16
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 line,
  output logic                 load,
  output logic                 load_ferr,
  output logic [DATA_BITS-1:0] load_data
);
  localparam int CNT_W = $clog2(OVERSAMPLE);
  localparam int BIT_W = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
  localparam logic [CNT_W-1:0] MID_CNT  = CNT_W'(OVERSAMPLE/2 - 1);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(OVERSAMPLE - 1);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_BITS - 1);

  rx_state_t            state;
  logic [CNT_W-1:0]     div;
  logic [BIT_W-1:0]     bitn;
  logic [DATA_BITS-1:0] shreg;
  logic                 armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= RX_IDLE;
      div       <= '0;
      bitn      <= '0;
      shreg     <= '0;
      armed     <= 1'b0;
      load      <= 1'b0;
      load_ferr <= 1'b0;
    end else begin
      load <= 1'b0;
      if (tick) begin
        case (state)
          RX_IDLE: begin
            // A start is accepted only after the line was seen high
            if (line) begin
              armed <= 1'b1;
            end else if (armed) begin
              armed <= 1'b0;
              div   <= '0;
              state <= RX_START;
            end
          end
          RX_START: begin
            if (div == MID_CNT) begin
              div <= '0;
              if (!line) begin
                bitn  <= '0;
                state <= RX_DATA;
              end else begin
                state <= RX_IDLE;
              end
            end else begin
              div <= div + 1'b1;
            end
          end
          RX_DATA: begin
            if (div == LAST_CNT) begin
              div   <= '0;
              shreg <= {line, shreg[DATA_BITS-1:1]};
              if (bitn == LAST_BIT) state <= RX_STOP;
              else                  bitn  <= bitn + 1'b1;
            end else begin
              div <= div + 1'b1;
            end
          end
          RX_STOP: begin
            if (div == LAST_CNT) begin
              div       <= '0;
              load      <= 1'b1;
              load_ferr <= ~line;
              state     <= RX_IDLE;
            end else begin
              div <= div + 1'b1;
            end
          end
          default: state <= RX_IDLE;
        endcase
      end
    end
  end

  assign load_data = shreg;
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
  parameter int DATA_BITS = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 load_ferr,
  input  logic [DATA_BITS-1:0] load_data,
  input  logic                 rd_n,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 data_ready,
  output logic                 overrun,
  output logic                 frame_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data    <= '0;
      data_ready <= 1'b0;
      overrun    <= 1'b0;
      frame_err  <= 1'b0;
    end else if (load) begin
      // A load wins over a read in the same cycle
      rx_data    <= load_data;
      frame_err  <= load_ferr;
      data_ready <= 1'b1;
      if (data_ready && rd_n) overrun <= 1'b1;
    end else if (!rd_n) begin
      data_ready <= 1'b0;
      overrun    <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_dbuf.sv
module serial_rx_dbuf #(
  parameter int DATA_BITS   = 8,
  parameter int OVERSAMPLE  = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tick,
  input  logic                 rxd_in,
  input  logic                 rd_n,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 data_ready,
  output logic                 overrun,
  output logic                 frame_err
);
  logic                 line_s;
  logic                 load;
  logic                 load_ferr;
  logic [DATA_BITS-1:0] load_data;

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd_in),
    .dout(line_s)
  );

  rx_frame_engine #(.DATA_BITS(DATA_BITS), .OVERSAMPLE(OVERSAMPLE)) u_engine (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .line     (line_s),
    .load     (load),
    .load_ferr(load_ferr),
    .load_data(load_data)
  );

  rx_hold_reg #(.DATA_BITS(DATA_BITS)) u_hold (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_ferr (load_ferr),
    .load_data (load_data),
    .rd_n      (rd_n),
    .rx_data   (rx_data),
    .data_ready(data_ready),
    .overrun   (overrun),
    .frame_err (frame_err)
  );
endmodule

// File: rtl/serial_rx_dbuf_chk.sv
module serial_rx_dbuf_chk #(
  parameter int DATA_BITS = 8
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 rd_n,
  input logic                 load,
  input logic                 load_ferr,
  input logic [DATA_BITS-1:0] rx_data,
  input logic                 data_ready,
  input logic                 overrun,
  input logic                 frame_err
);
  p_load_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> !load);

  p_ready_after_load_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> data_ready);

  p_read_clears_r6: assert property (@(posedge clk) disable iff (rst)
    (!rd_n && !load) |=> (!data_ready && !overrun));

  p_overrun_set_r8: assert property (@(posedge clk) disable iff (rst)
    (load && data_ready && rd_n) |=> overrun);

  p_overrun_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (overrun && rd_n) |=> overrun);

  p_ferr_follows_stop_r9: assert property (@(posedge clk) disable iff (rst)
    load |=> (frame_err == $past(load_ferr)));

  p_data_stable_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(rx_data));
endmodule

bind serial_rx_dbuf serial_rx_dbuf_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rd_n      (rd_n),
  .load      (load),
  .load_ferr (load_ferr),
  .rx_data   (rx_data),
  .data_ready(data_ready),
  .overrun   (overrun),
  .frame_err (frame_err)
);

// File: tb/serial_rx_dbuf_test.sv
`timescale 1ns/1ps
module serial_rx_dbuf_test;
  localparam int BIT_CLKS = 64;  // 16 ticks, one tick every 4 clocks

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       rxd_in = 1'b1;
  logic       rd_n = 1'b1;
  logic [7:0] rx_data;
  logic       data_ready, overrun, frame_err;

  int total = 0;
  int bad = 0;
  int received = 0;
  int sent = 0;
  bit auto_read = 1'b1;
  bit finished = 1'b0;
  logic [8:0] expq[$];  // {frame_err, data}
  logic [1:0] tdiv = '0;

  serial_rx_dbuf uut (
    .clk(clk), .rst(rst), .tick(tick), .rxd_in(rxd_in), .rd_n(rd_n),
    .rx_data(rx_data), .data_ready(data_ready), .overrun(overrun),
    .frame_err(frame_err)
  );

  always #2 clk = ~clk;

  always @(posedge clk) begin
    tdiv <= tdiv + 2'd1;
    tick <= (tdiv == 2'd3);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold_bits(input int n);
    repeat (n * BIT_CLKS) @(negedge clk);
  endtask

  // Driver: one frame, LSB first, with a chosen stop level
  task automatic send_frame(input logic [7:0] b, input logic stop, input bit push);
    if (push) begin
      expq.push_back({~stop, b});
      sent++;
    end
    rxd_in = 1'b0;
    hold_bits(1);
    for (int i = 0; i < 8; i++) begin
      rxd_in = b[i];
      hold_bits(1);
    end
    rxd_in = stop;
    hold_bits(1);
    rxd_in = 1'b1;
  endtask

  // Monitor: compare each ready byte against the scoreboard, then read it
  always @(negedge clk) begin
    if (auto_read && rd_n && data_ready) begin
      received++;
      if (expq.size() == 0) begin
        check(1'b0, "R2 unexpected byte", rx_data, 0);
      end else begin
        logic [8:0] e;
        e = expq.pop_front();
        check(rx_data == e[7:0], "R3 data", rx_data, e[7:0]);
        check(frame_err == e[8], "R9 frame_err", frame_err, e[8]);
      end
      rd_n = 1'b0;
      @(negedge clk);
      rd_n = 1'b1;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(data_ready == 1'b0, "R1 data_ready", data_ready, 0);
    check(overrun == 1'b0, "R1 overrun", overrun, 0);
    check(frame_err == 1'b0, "R1 frame_err", frame_err, 0);
    rst = 1'b0;
    hold_bits(2);

    // R3 R4 R5 R7: back-to-back frames, varied patterns
    send_frame(8'hA5, 1'b1, 1'b1);
    send_frame(8'h3C, 1'b1, 1'b1);
    send_frame(8'h00, 1'b1, 1'b1);
    send_frame(8'hFF, 1'b1, 1'b1);
    send_frame(8'h01, 1'b1, 1'b1);
    send_frame(8'h80, 1'b1, 1'b1);
    hold_bits(2);

    // R2: glitch shorter than half a bit is rejected
    rxd_in = 1'b0;
    repeat (16) @(negedge clk);
    rxd_in = 1'b1;
    hold_bits(3);
    check(data_ready == 1'b0, "R2 glitch no byte", data_ready, 0);
    check(received == sent, "R2 glitch count", received, sent);

    // R9: low stop bit, byte still delivered; line must return high first
    send_frame(8'h5A, 1'b0, 1'b1);
    hold_bits(2);
    send_frame(8'hC3, 1'b1, 1'b1);
    hold_bits(2);

    // R8: two frames without reading
    auto_read = 1'b0;
    repeat (4) @(negedge clk);
    send_frame(8'h11, 1'b1, 1'b0);
    check(data_ready == 1'b1, "R7 first unread", data_ready, 1);
    check(overrun == 1'b0, "R8 no overrun yet", overrun, 0);
    send_frame(8'h22, 1'b1, 1'b0);
    hold_bits(1);
    check(data_ready == 1'b1, "R8 ready", data_ready, 1);
    check(overrun == 1'b1, "R8 overrun", overrun, 1);
    check(rx_data == 8'h22, "R8 overwrite", rx_data, 8'h22);
    hold_bits(1);
    check(overrun == 1'b1, "R8 sticky", overrun, 1);

    // R6: one-cycle read strobe clears both flags, data unchanged
    rd_n = 1'b0;
    @(negedge clk);
    rd_n = 1'b1;
    check(data_ready == 1'b0, "R6 ready cleared", data_ready, 0);
    check(overrun == 1'b0, "R6 overrun cleared", overrun, 0);
    check(rx_data == 8'h22, "R4 data held", rx_data, 8'h22);

    // R7: reception continues normally after an overrun
    auto_read = 1'b1;
    send_frame(8'h6E, 1'b1, 1'b1);
    hold_bits(2);
    check(expq.size() == 0, "R7 queue drained", expq.size(), 0);
    check(received == sent, "R7 byte count", received, sent);

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule